// File: doc/BRIEF.md
# Banked Register File with Password Write Lock

This block is a byte-wide register space with 256 addresses. A serial-bus slave front end, which is not part of the block, reaches it through single-cycle read and write strobes. Addresses 00h to 7Fh always map to the same lower region. The upper half, 80h to FFh, is a window whose contents depend on a bank-select byte held at 7Fh. Bank 1 is a 48-byte configuration bank. Banks 2 and 3 hold 72 bytes each, and banks 4 and 5 hold 64 bytes each.

Every storage byte is backed by a nonvolatile layer. That layer is modelled as a second array, plus a busy flag that covers the slow commit and the recall after reset. Writes to storage bytes go through a password check. A 16-bit entry word at 78h/79h must equal the 16-bit key kept in the first two bytes of bank 1. A mirror-only mode bit in bank 1 makes two address ranges behave as volatile scratch space that never reaches the nonvolatile layer. Accepted writes wait in a small queue and are committed only after the bus reports a stop condition.

Top module: `banked_regfile`

## Requirements
- R1: After reset, `nv_busy` is high while the nonvolatile array is copied into the live array, and then drops. At reset the bank select reads 00h and the entry word holds FFFFh. A nonvolatile image with no write history reads 00h everywhere except the key bytes.
- R2: `rd_valid` pulses in the cycle after each `bus_rd`, carrying the addressed byte. Addresses 00h to 77h return the same data whatever the bank select is.
- R3: Byte 7Fh is the bank select, readable and always writable. With select 1 to 5, the upper window maps 48, 72, 72, 64 or 64 bytes starting at 80h. Upper addresses past the bank size, and the whole window with select 0 or 6 to 255, read 00h and ignore writes.
- R4: The entry word is write-only: 78h takes the high byte and 79h the low byte. Both addresses always read 00h.
- R5: The stored key is bank-1 offset 0 (80h, high byte) and offset 1 (81h, low byte). Its default is FFFFh, so after reset the block is unlocked until the key changes. Writes are unlocked exactly while the entry word equals the key.
- R6: A write to any storage byte while locked changes neither the live nor the nonvolatile copy.
- R7: The mirror-only bit is bit 0 of bank-1 offset 47 (AFh). While it is 1, writes to 20h–3Fh and to bank-1 offsets 0–39 (80h–A7h) update only the live copy. After the next reset these bytes show the last value committed while the bit was 0.
- R8: Accepted writes to other storage bytes queue up, PEND_DEPTH at most; further writes are dropped. A `bus_stop` with a non-empty queue raises `nv_busy` in the next cycle and commits each queued byte in COMMIT_CYCLES cycles. Writes to storage bytes during `nv_busy` are ignored. Queued bytes that are lost to a reset before the stop are not committed.
- R9: The unimplemented lower addresses 7Ah to 7Eh read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the recall |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_stop | input | 1 | Pulse marking the bus stop condition |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | 8 | Read data |
| nv_busy | output | 1 | Recall or commit in progress |

## Verification
The bench builds the block with PEND_DEPTH=4 and COMMIT_CYCLES=3. With this small queue, five back-to-back writes overflow it and show that the fifth byte is dropped. The short commit time allows the exact busy length for a full queue to be counted, 12 cycles. The bench also resets the block in the middle of a session. This proves that mirror-only writes and uncommitted queue entries are lost, while committed bytes come back, including a changed key that leaves the block locked.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;

  // region sizes in bytes
  parameter int LOW_SIZE  = 120;  // 00h..77h
  parameter int T1_SIZE   = 48;
  parameter int T23_SIZE  = 72;
  parameter int T45_SIZE  = 64;
  parameter int NUM_TABLES = 5;

  localparam int T1_BASE = LOW_SIZE;
  localparam int T2_BASE = T1_BASE + T1_SIZE;
  localparam int T3_BASE = T2_BASE + T23_SIZE;
  localparam int T4_BASE = T3_BASE + T23_SIZE;
  localparam int T5_BASE = T4_BASE + T45_SIZE;
  localparam int TOTAL   = T5_BASE + T45_SIZE;
  localparam int IDX_W   = $clog2(TOTAL);

  // fixed addresses and offsets the behaviour depends on
  localparam logic [ADDR_W-1:0] PWE_HI_ADDR  = 8'h78;
  localparam logic [ADDR_W-1:0] PWE_LO_ADDR  = 8'h79;
  localparam logic [ADDR_W-1:0] TSEL_ADDR    = 8'h7F;
  localparam logic [ADDR_W-1:0] MIRROR_FIRST = 8'h20;
  localparam logic [ADDR_W-1:0] MIRROR_LAST  = 8'h3F;
  localparam int T1_MIRROR_SIZE = 40;
  localparam int KEY_HI_OFF     = 0;
  localparam int KEY_LO_OFF     = 1;
  localparam int MODE_OFF       = 47;

  typedef struct packed {
    logic             hit;
    logic             mirror;
    logic             pwe_hi;
    logic             pwe_lo;
    logic             tsel;
    logic [IDX_W-1:0] idx;
  } dec_t;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } pend_t;

  function automatic int tbl_size(int t);
    case (t)
      1:       return T1_SIZE;
      2, 3:    return T23_SIZE;
      default: return T45_SIZE;
    endcase
  endfunction

  function automatic int tbl_base(int t);
    case (t)
      1:       return T1_BASE;
      2:       return T2_BASE;
      3:       return T3_BASE;
      4:       return T4_BASE;
      default: return T5_BASE;
    endcase
  endfunction
endpackage

// File: rtl/brf_decode.sv
module brf_decode
  import banked_regfile_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] tsel,
  output dec_t              dec
);
  logic [NUM_TABLES-1:0] tbl_hit;
  logic [IDX_W-1:0]      tbl_idx [NUM_TABLES];
  logic [ADDR_W-1:0]     off;

  assign off = {1'b0, addr[ADDR_W-2:0]};

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    localparam int SZ   = tbl_size(t + 1);
    localparam int BASE = tbl_base(t + 1);
    assign tbl_hit[t] = addr[ADDR_W-1] && (tsel == DATA_W'(t + 1)) &&
                        (off < ADDR_W'(SZ));
    assign tbl_idx[t] = IDX_W'(BASE) + IDX_W'(off);
  end

  always_comb begin
    dec = '0;
    if (!addr[ADDR_W-1]) begin
      if (addr < ADDR_W'(LOW_SIZE)) begin
        dec.hit    = 1'b1;
        dec.idx    = IDX_W'(addr);
        dec.mirror = (addr >= MIRROR_FIRST) && (addr <= MIRROR_LAST);
      end
      dec.pwe_hi = (addr == PWE_HI_ADDR);
      dec.pwe_lo = (addr == PWE_LO_ADDR);
      dec.tsel   = (addr == TSEL_ADDR);
    end else begin
      for (int t = 0; t < NUM_TABLES; t++) begin
        if (tbl_hit[t]) begin
          dec.hit = 1'b1;
          dec.idx = tbl_idx[t];
        end
      end
      dec.mirror = tbl_hit[0] && (off < ADDR_W'(T1_MIRROR_SIZE));
    end
  end
endmodule

// File: rtl/brf_pend_fifo.sv
module brf_pend_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 17,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/brf_nv_store.sv
module brf_nv_store
  import banked_regfile_pkg::*;
#(
  parameter int COMMIT_CYCLES = 4,
  parameter int CNT_W         = 4,
  localparam int CC_W = $clog2(COMMIT_CYCLES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  pend_t             head,
  input  logic [CNT_W-1:0]  pend_count,
  output logic              pend_pop,
  output logic              rc_we,
  output logic [IDX_W-1:0]  rc_idx,
  output logic [DATA_W-1:0] rc_data,
  output logic              recalling,
  output logic              committing
);
  logic [DATA_W-1:0] nv_mem [TOTAL];
  logic [CC_W-1:0]   cnt;
  logic              rc_run;
  logic [IDX_W-1:0]  rc_ptr;

  // image of a part with no write history: key bytes all ones
  initial begin
    for (int i = 0; i < TOTAL; i++) begin
      nv_mem[i] = (i == T1_BASE + KEY_HI_OFF || i == T1_BASE + KEY_LO_OFF)
                  ? 8'hFF : 8'h00;
    end
  end

  assign pend_pop  = committing && (cnt == CC_W'(COMMIT_CYCLES - 1));
  assign recalling = rc_run || rc_we;

  // dual-port array: commit writes, recall reads
  always_ff @(posedge clk) begin
    if (pend_pop) nv_mem[head.idx] <= head.data;
    if (rc_run)   rc_data <= nv_mem[rc_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      committing <= 1'b0;
      cnt        <= '0;
    end else if (!committing) begin
      if (start) begin
        committing <= 1'b1;
        cnt        <= '0;
      end
    end else if (cnt == CC_W'(COMMIT_CYCLES - 1)) begin
      cnt <= '0;
      if (pend_count == CNT_W'(1)) committing <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_run <= 1'b1;
      rc_ptr <= '0;
      rc_we  <= 1'b0;
      rc_idx <= '0;
    end else begin
      rc_we  <= rc_run;
      rc_idx <= rc_ptr;
      if (rc_run) begin
        if (rc_ptr == IDX_W'(TOTAL - 1)) rc_run <= 1'b0;
        else                             rc_ptr <= rc_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int PEND_DEPTH    = 8,
  parameter int COMMIT_CYCLES = 4,
  localparam int PCNT_W = $clog2(PEND_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_stop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              nv_busy
);
  dec_t                dec;
  logic                dec_hit, dec_mirror;
  logic [DATA_W-1:0]   tsel_q;
  logic [15:0]         pwe_q, key_q;
  logic                mode_q, unlocked;

  logic                nv_ok, mirror_wr, push;
  logic                vol_we;
  logic [IDX_W-1:0]    vol_idx;
  logic [DATA_W-1:0]   vol_wd;
  logic [DATA_W-1:0]   vol_mem [TOTAL];
  logic [DATA_W-1:0]   mem_q, aux_q;
  logic                src_mem_q;

  pend_t               pend_din, pend_head;
  logic [$bits(pend_t)-1:0] head_raw;
  logic                pend_full, pend_empty, pend_pop;
  logic [PCNT_W-1:0]   pend_count;

  logic                rc_we, recalling, committing, start;
  logic [IDX_W-1:0]    rc_idx;
  logic [DATA_W-1:0]   rc_data;

  brf_decode u_dec (.addr(bus_addr), .tsel(tsel_q), .dec(dec));

  assign dec_hit    = dec.hit;
  assign dec_mirror = dec.mirror;
  assign unlocked   = (pwe_q == key_q);
  assign nv_busy    = recalling || committing;

  always_comb begin
    nv_ok     = bus_wr && dec_hit && unlocked && !nv_busy;
    mirror_wr = nv_ok && dec_mirror && mode_q;
    push      = nv_ok && !mirror_wr && !pend_full;
    vol_we    = rc_we || mirror_wr || push;
    vol_idx   = rc_we ? rc_idx  : dec.idx;
    vol_wd    = rc_we ? rc_data : bus_wdata;
    pend_din  = '{idx: dec.idx, data: bus_wdata};
    start     = bus_stop && !pend_empty && !nv_busy;
  end

  brf_pend_fifo #(.DEPTH(PEND_DEPTH), .W($bits(pend_t))) u_pend (
    .clk(clk), .rst(rst), .push(push), .din(pend_din), .pop(pend_pop),
    .dout(head_raw), .full(pend_full), .empty(pend_empty), .count(pend_count)
  );
  assign pend_head = pend_t'(head_raw);

  brf_nv_store #(.COMMIT_CYCLES(COMMIT_CYCLES), .CNT_W(PCNT_W)) u_nv (
    .clk(clk), .rst(rst), .start(start), .head(pend_head),
    .pend_count(pend_count), .pend_pop(pend_pop), .rc_we(rc_we),
    .rc_idx(rc_idx), .rc_data(rc_data), .recalling(recalling),
    .committing(committing)
  );

  // live array, single write port and one synchronous read port
  always_ff @(posedge clk) begin
    if (vol_we) vol_mem[vol_idx] <= vol_wd;
    if (bus_rd) mem_q <= vol_mem[dec.idx];
  end

  // copies of the key and mode bit, refreshed on every live write
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= 16'hFFFF;
      mode_q <= 1'b0;
    end else if (vol_we) begin
      if (vol_idx == IDX_W'(T1_BASE + KEY_HI_OFF)) key_q[15:8] <= vol_wd;
      if (vol_idx == IDX_W'(T1_BASE + KEY_LO_OFF)) key_q[7:0]  <= vol_wd;
      if (vol_idx == IDX_W'(T1_BASE + MODE_OFF))   mode_q      <= vol_wd[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsel_q <= '0;
      pwe_q  <= 16'hFFFF;
    end else if (bus_wr) begin
      if (dec.tsel)   tsel_q      <= bus_wdata;
      if (dec.pwe_hi) pwe_q[15:8] <= bus_wdata;
      if (dec.pwe_lo) pwe_q[7:0]  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      src_mem_q <= 1'b0;
      aux_q     <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) begin
        src_mem_q <= dec_hit && !recalling;
        aux_q     <= dec.tsel ? tsel_q : '0;
      end
    end
  end

  assign rd_data = src_mem_q ? mem_q : aux_q;
endmodule

// File: rtl/brf_chk.sv
module brf_chk #(
  parameter int PEND_DEPTH = 8,
  localparam int PCNT_W = $clog2(PEND_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_addr,
  input logic              bus_stop,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              nv_busy,
  input logic [7:0]        tsel_q,
  input logic              dec_hit,
  input logic              dec_mirror,
  input logic              mode_q,
  input logic              unlocked,
  input logic              committing,
  input logic [PCNT_W-1:0] pend_count
);
  p_recall_busy_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> nv_busy);

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);

  p_rd_origin_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_rd));

  p_window_off_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[7] && (tsel_q == 8'd0 || tsel_q > 8'd5)) |=> rd_data == 8'h00);

  p_pwe_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 8'h78 || bus_addr == 8'h79)) |=> rd_data == 8'h00);

  p_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_hit && !unlocked && !nv_busy) |=> $stable(pend_count));

  p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_hit && dec_mirror && mode_q && !nv_busy) |=> $stable(pend_count));

  p_commit_stop_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(committing) |-> $past(bus_stop));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    pend_count <= PCNT_W'(PEND_DEPTH));
endmodule

bind banked_regfile brf_chk #(.PEND_DEPTH(PEND_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_stop(bus_stop), .rd_valid(rd_valid),
  .rd_data(rd_data), .nv_busy(nv_busy), .tsel_q(tsel_q),
  .dec_hit(dec_hit), .dec_mirror(dec_mirror), .mode_q(mode_q),
  .unlocked(unlocked), .committing(committing), .pend_count(pend_count)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam int PD = 4;
  localparam int CC = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_stop = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       rd_valid, nv_busy;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  banked_regfile #(.PEND_DEPTH(PD), .COMMIT_CYCLES(CC)) u_banked_regfile (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stop(bus_stop),
    .rd_valid(rd_valid), .rd_data(rd_data), .nv_busy(nv_busy)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design returns read data
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk("R2 unrequested data", 16'(rd_valid), 16'h0);
      else chk(tag_q.pop_front(), 16'(rd_data), 16'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic stop_bus();
    bus_stop = 1'b1;
    @(negedge clk);
    bus_stop = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (nv_busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, 16'(nv_busy), 16'h0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy right after reset", 16'(nv_busy), 16'h1);
    wait_idle("R1 recall finishes");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // reset state, unimplemented bytes
    rd(8'h7F, 8'h00, "R1 bank select resets to 0");
    rd(8'h78, 8'h00, "R4 entry high reads 0");
    rd(8'h79, 8'h00, "R4 entry low reads 0");
    for (int a = 8'h7A; a <= 8'h7E; a++) rd(8'(a), 8'h00, "R9 unimplemented reads 0");
    rd(8'h10, 8'h00, "R1 blank image reads 0");

    // bank 1 and default key
    wr(8'h7F, 8'h01);
    rd(8'h7F, 8'h01, "R3 bank select readback");
    rd(8'h80, 8'hFF, "R5 key high default");
    rd(8'h81, 8'hFF, "R5 key low default");

    // first commit: held until stop
    wr(8'h10, 8'h5A);
    wr(8'h25, 8'hA1);
    wr(8'h90, 8'hB2);
    @(negedge clk);
    chk("R8 no commit before stop", 16'(nv_busy), 16'h0);
    stop_bus();
    chk("R8 busy after stop", 16'(nv_busy), 16'h1);
    wait_idle("R8 commit ends");
    rd(8'h10, 8'h5A, "R2 lower write readback");
    rd(8'h25, 8'hA1, "R7 prep 25h");
    rd(8'h90, 8'hB2, "R7 prep bank1 90h");

    // bank mapping and window bounds
    wr(8'h7F, 8'h02);
    rd(8'h10, 8'h5A, "R2 lower unaffected by bank 2");
    wr(8'hC7, 8'h33);
    rd(8'hC7, 8'h33, "R3 bank 2 last byte");
    wr(8'h7F, 8'h04);
    wr(8'hC7, 8'h44);
    rd(8'hC7, 8'h00, "R3 bank 4 past end");
    wr(8'hBF, 8'h55);
    rd(8'hBF, 8'h55, "R3 bank 4 last byte");
    wr(8'h7F, 8'h00);
    wr(8'h80, 8'h11);
    rd(8'h80, 8'h00, "R3 bank 0 window empty");
    wr(8'h7F, 8'h07);
    rd(8'h80, 8'h00, "R3 bank 7 window empty");
    wr(8'h7F, 8'h02);
    rd(8'h80, 8'h00, "R3 ignored write did not land");
    rd(8'hC7, 8'h33, "R3 bank 2 kept after bank 4 write");
    stop_bus();
    wait_idle("R8 commit ends");

    // entry word is write-only
    wr(8'h78, 8'h12);
    rd(8'h78, 8'h00, "R4 entry high still reads 0");
    wr(8'h78, 8'hFF);

    // change the key to 1234h step by step
    wr(8'h7F, 8'h01);
    wr(8'h80, 8'h12);
    wr(8'h78, 8'h12);
    wr(8'h81, 8'h34);
    wr(8'h79, 8'h34);
    stop_bus();
    wait_idle("R8 commit ends");
    rd(8'h80, 8'h12, "R5 key high stored");
    rd(8'h81, 8'h34, "R5 key low stored");
    wr(8'h79, 8'h00);
    wr(8'h10, 8'h77);
    rd(8'h10, 8'h5A, "R6 locked write ignored");
    wr(8'h79, 8'h34);
    wr(8'h10, 8'h77);
    rd(8'h10, 8'h77, "R6 unlocked write accepted");
    stop_bus();
    wait_idle("R8 commit ends");

    // writes during commit are ignored
    wr(8'h11, 8'h01);
    stop_bus();
    wr(8'h12, 8'h02);
    wait_idle("R8 commit ends");
    rd(8'h12, 8'h00, "R8 write during busy ignored");
    rd(8'h11, 8'h01, "R8 committed byte");

    // queue overflow and exact busy length
    for (int i = 0; i <= PD; i++) wr(8'(8'h40 + i), 8'(8'h40 + i));
    rd(8'(8'h40 + PD), 8'h00, "R8 overflow byte dropped");
    rd(8'(8'h40 + PD - 1), 8'(8'h40 + PD - 1), "R8 last queued byte");
    stop_bus();
    begin
      int n = 0;
      while (nv_busy && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R8 busy length full queue", 16'(n), 16'(PD * CC));
    end

    // mirror-only mode
    wr(8'hAF, 8'h01);
    stop_bus();
    wait_idle("R8 commit ends");
    wr(8'h25, 8'hC3);
    wr(8'h90, 8'hD4);
    stop_bus();
    chk("R7 mirror writes queue nothing", 16'(nv_busy), 16'h0);
    rd(8'h25, 8'hC3, "R7 mirror live 25h");
    rd(8'h90, 8'hD4, "R7 mirror live 90h");
    wr(8'hA8, 8'h66);
    stop_bus();
    chk("R7 A8h outside mirror range commits", 16'(nv_busy), 16'h1);
    wait_idle("R8 commit ends");
    wr(8'h50, 8'h9C);

    // reset: recall committed image
    do_reset();
    rd(8'h7F, 8'h00, "R1 bank select after reset");
    wr(8'h7F, 8'h01);
    rd(8'h25, 8'hA1, "R7 25h back to committed value");
    rd(8'h90, 8'hB2, "R7 90h back to committed value");
    rd(8'hA8, 8'h66, "R7 A8h kept");
    rd(8'hAF, 8'h01, "R7 mode byte kept");
    rd(8'h80, 8'h12, "R5 key kept");
    rd(8'h50, 8'h00, "R8 uncommitted byte lost");
    rd(8'h10, 8'h77, "R8 committed byte kept");
    rd(8'h44, 8'h00, "R8 dropped byte stays 0");
    wr(8'h60, 8'hAA);
    rd(8'h60, 8'h00, "R6 locked after reset with new key");
    wr(8'h78, 8'h12);
    wr(8'h79, 8'h34);
    wr(8'h60, 8'hAA);
    rd(8'h60, 8'hAA, "R6 unlocked with matching entry");

    repeat (3) @(negedge clk);
    chk("R2 every read answered", 16'(exp_q.size()), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule